// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block bridges a clocked request interface to an external asynchronous static RAM of 512K words by 16 bits. On-chip logic presents an address, a write word, two byte enables and a read/write flag with a valid/ready handshake. The controller drives the memory's active-low select, output-enable, write-enable and per-byte strobes, and a tri-state data bus split into an output word, a drive enable and an input word. For a read it returns the captured word with a one-cycle done pulse; for a write it pulses done once the write window has closed.

Every access phase is timed by a down-counter. The counter limits are cycle counts derived at elaboration from the clock period and the speed grade (45, 55 or 70 ns) by ceiling division. A level-sensitive retention request parks the memory deselected so the supply may be lowered. When the request drops, the controller waits one read cycle time before it accepts further work.

The state machine has seven states. IDLE accepts a request or, with priority, a retention request. RD_ACC holds the read window, and RD_TURN is the bus turnaround after it. WR_SETUP is the quiet cycle before a write, and WR_PULSE is the write window. RET_HOLD is the parked retention state, and RET_RECOV is the recovery wait. The transitions are:
- IDLE to RET_HOLD when retention is requested.
- IDLE to RD_ACC on a read request, or IDLE to WR_SETUP on a write request.
- RD_ACC to RD_TURN, RD_TURN to IDLE, and WR_PULSE to IDLE, each when its counter expires.
- WR_SETUP to WR_PULSE after one cycle.
- RET_HOLD to RET_RECOV when retention is released.
- RET_RECOV to IDLE when its counter expires.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, select, output enable, write enable and both strobes are high, the data bus is not driven, ready is high and the retention acknowledge is low.
- R2: Whenever the controller is ready for a request, the memory is deselected, either because select is high or because both strobes are high.
- R3: A read holds select low, output enable low and write enable high for exactly ceil(grade/clock) cycles (12 at 45 ns and 4 ns). During those cycles the lower strobe is low exactly when enable bit 0 is set, and the upper strobe is low exactly when enable bit 1 is set.
- R4: On read completion, done is high for one cycle. The returned word carries the memory's bits 7:0 when enable bit 0 is set and bits 15:8 when enable bit 1 is set. A disabled lane returns zero.
- R5: A write holds select and write enable low together, with output enable high and the strobes following the enables as in R3. Only the enabled lanes change in memory, and a write with both enables clear changes nothing.
- R6: The data bus is driven only while write enable is low, and during that time it carries the request's write word. The controller and the memory never drive the bus in the same cycle.
- R7: Write enable falls only after a cycle with output enable high and the bus undriven. After a read, ready stays low for ceil(hold-off/clock) turnaround cycles, where the hold-off is 20 ns, or 25 ns at the 70 ns grade (5 cycles at 45 ns and 4 ns).
- R8: The write window lasts exactly ceil(max(pulse, select-to-end, data-setup)/clock) cycles (12 at 45 ns and 4 ns).
- R9: While retention is requested from idle, the memory is deselected, retention is acknowledged, ready is low, and a pending request is neither accepted nor completed.
- R10: After retention is released, ready stays low for exactly ceil(grade/clock) cycles (12 at 45 ns and 4 ns), and stored data is intact afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_be | input | 2 | Bit 0 enables bits 7:0, bit 1 enables bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word, valid with rsp_done after a read |
| ret_req | input | 1 | Retention request (level) |
| ret_ack | output | 1 | Memory parked, supply may be reduced |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_out | output | DATA_W | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The assertions rely on the requester holding ret_req stable long enough for the controller to reach a phase boundary. They also rely on the memory model releasing the bus within the turnaround hold-off. The stimulus changes inputs only at falling clock edges. It issues each request only while ready is high and lowers req_valid right after acceptance, except in the retention case, where the request is deliberately held to show it is ignored. The bench's memory model keeps driving read data for four cycles after output enable is released, which stays within the five-cycle turnaround.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_RET_HOLD,
        ST_RET_RECOV
    } ctrl_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // minimum overlap of select and write enable
    function automatic int grade_pulse_ns(input int grade);
        return (grade >= 70) ? 55 : 45;
    endfunction

    // select / address valid before the end of the write
    function automatic int grade_sel_end_ns(input int grade);
        return (grade >= 70) ? 60 : 45;
    endfunction

    // write data stable before the end of the write
    function automatic int grade_dsetup_ns(input int grade);
        return (grade <= 45) ? 25 : 30;
    endfunction

    // memory may hold the bus this long after release
    function automatic int grade_holdoff_ns(input int grade);
        return (grade >= 70) ? 25 : 20;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    en,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] bus_in,
    output logic [LANES-1:0]        strb_n,
    output logic [LANES*LANE_W-1:0] lane_data
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb_n[i] = !(en && be[i]);
        assign lane_data[i*LANE_W +: LANE_W] = be[i] ? bus_in[i*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 4,
    parameter int SPEED_NS = 45,
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              ret_req,
    output logic              ret_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int LANE_W  = DATA_W / 2;
    localparam int RD_CYC  = ceil_div(SPEED_NS, CLK_NS);
    localparam int WR_NS   = max_int(grade_pulse_ns(SPEED_NS),
                             max_int(grade_sel_end_ns(SPEED_NS), grade_dsetup_ns(SPEED_NS)));
    localparam int WR_CYC  = ceil_div(WR_NS, CLK_NS);
    localparam int TA_CYC  = ceil_div(grade_holdoff_ns(SPEED_NS), CLK_NS);
    localparam int RC_CYC  = RD_CYC;
    localparam int MAX_CYC = max_int(max_int(RD_CYC, WR_CYC), max_int(TA_CYC, RC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RC_CYC - 1);

    ctrl_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        be_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              lane_en;
    logic [1:0]        strb_n;
    logic [DATA_W-1:0] lane_data;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_lane_decode #(.LANES(2), .LANE_W(LANE_W)) u_lanes (
        .en        (lane_en),
        .be        (be_q),
        .bus_in    (mem_dq_in),
        .strb_n    (strb_n),
        .lane_data (lane_data)
    );

    assign accept = (state_q == ST_IDLE) && !ret_req && req_valid;

    // next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_req) begin
                    state_d = ST_RET_HOLD;
                end else if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_last) begin
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TA_LOAD;
                end
            end
            ST_RD_TURN: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WR_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_RET_HOLD: begin
                if (!ret_req) begin
                    state_d  = ST_RET_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = RC_LOAD;
                end
            end
            ST_RET_RECOV: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request/response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ((state_q == ST_RD_ACC) || (state_q == ST_WR_PULSE)) && tmr_last;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if ((state_q == ST_RD_ACC) && tmr_last) begin
                rdata_q <= lane_data;
            end
        end
    end

    // memory-side and request-side outputs
    always_comb begin
        lane_en    = (state_q == ST_RD_ACC) || (state_q == ST_WR_PULSE);
        mem_cs_n   = !lane_en;
        mem_oe_n   = (state_q != ST_RD_ACC);
        mem_we_n   = (state_q != ST_WR_PULSE);
        mem_dq_oe  = (state_q == ST_WR_PULSE);
        mem_dq_out = wdata_q;
        mem_addr   = addr_q;
        req_ready  = (state_q == ST_IDLE) && !ret_req;
        ret_ack    = (state_q == ST_RET_HOLD);
    end

    assign mem_lb_n  = strb_n[0];
    assign mem_ub_n  = strb_n[1];
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 4,
    parameter int SPEED_NS = 45
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_done,
    input logic ret_ack,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_ub_n,
    input logic mem_lb_n,
    input logic mem_dq_oe
);

    localparam int WR_MIN = ceil_div(max_int(grade_pulse_ns(SPEED_NS),
                            max_int(grade_sel_end_ns(SPEED_NS), grade_dsetup_ns(SPEED_NS))), CLK_NS);

    logic [15:0] we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= '0;
        end else if (mem_we_n) begin
            we_run <= '0;
        end else if (we_run != 16'hFFFF) begin
            we_run <= we_run + 16'd1;
        end
    end

    a_r2_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n || (mem_ub_n && mem_lb_n)));

    a_r3_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r5_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    a_r7_quiet_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_dq_oe)));

    a_r8_write_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= 16'(WR_MIN)));

    a_r9_retention_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ack |-> (mem_cs_n && !req_ready));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.CLK_NS(CLK_NS), .SPEED_NS(SPEED_NS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .ret_ack   (ret_ack),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

    localparam int CLK_NS = 4;
    localparam int GRADE  = 45;
    localparam int RD_EXP = (GRADE + CLK_NS - 1) / CLK_NS;  // 12
    localparam int WR_EXP = (45 + CLK_NS - 1) / CLK_NS;     // max(45,45,25) -> 12
    localparam int TA_EXP = (20 + CLK_NS - 1) / CLK_NS;     // 5
    localparam int RC_EXP = RD_EXP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        ret_req = 1'b0;
    logic        ret_ack;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    int clash_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sram_lane_ctrl #(.CLK_NS(CLK_NS), .SPEED_NS(GRADE)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ret_req(ret_req), .ret_ack(ret_ack),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // behavioural memory: 256 words, strobe-aware, holds the bus after release
    logic [15:0] mem_model [0:255];
    logic [15:0] shadow    [0:255];
    logic [1:0]  drv = 2'b00;
    logic [15:0] rd_word = '0;
    int          tail = 0;

    assign mem_dq_in = {drv[1] ? rd_word[15:8] : 8'hA5, drv[0] ? rd_word[7:0] : 8'h5A};

    always @(negedge clk) begin
        if (drv != 2'b00 && mem_dq_oe) clash_cnt++;
        if (!mem_cs_n && !mem_we_n) begin
            if (!mem_lb_n) mem_model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mem_model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            drv     <= {!mem_ub_n, !mem_lb_n};
            rd_word <= mem_model[mem_addr[7:0]];
            tail    <= 4;
        end else if (tail > 0) begin
            tail <= tail - 1;
        end else begin
            drv <= 2'b00;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // issue one access; returns cycles with the strobe of interest low and violations
    task automatic access(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be,
                          output int lo, output int bad, output logic [15:0] rd);
        lo = 0;
        bad = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 200 && !rsp_done; n++) begin
            if (wr) begin
                if (!mem_we_n) begin
                    lo++;
                    if (mem_ub_n != !be[1] || mem_lb_n != !be[0]) bad++;
                    if (!mem_dq_oe || mem_dq_out != d) bad++;
                end
                if (!mem_oe_n) bad++;
            end else begin
                if (!mem_oe_n) begin
                    lo++;
                    if (mem_ub_n != !be[1] || mem_lb_n != !be[0] || mem_cs_n) bad++;
                end
                if (mem_dq_oe || !mem_we_n) bad++;
            end
            @(negedge clk);
        end
        if (!rsp_done) bad += 100;
        rd = rsp_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo, bad, t, seen;
        logic [15:0] rd, exp, msk;
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = '0;
            shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 strobes",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1F);
        check(!mem_dq_oe && req_ready && !ret_ack, "R1 handshake",
              {mem_dq_oe, req_ready, ret_ack}, 3'b010);
        check(rsp_rdata == 16'h0 && !rsp_done, "R1 response", rsp_rdata, 0);

        // R5 R8 full-word writes
        for (int a = 0; a < 16; a++) begin
            exp = 16'h1234 ^ (16'(a) * 16'h0F1D);
            access(1'b1, 19'(a * 17), exp, 2'b11, lo, bad, rd);
            shadow[a * 17] = exp;
            check(lo == WR_EXP, "R8 write window", lo, WR_EXP);
            check(bad == 0, "R5 R6 write signalling", bad, 0);
        end
        // R5 single-lane writes
        for (int a = 0; a < 16; a++) begin
            exp = {8'(8'hC0 - a), 8'(8'h40 + a)};
            if (a % 2 == 1) begin
                access(1'b1, 19'(a * 17), exp, 2'b10, lo, bad, rd);
                shadow[a * 17][15:8] = exp[15:8];
            end else begin
                access(1'b1, 19'(a * 17), exp, 2'b01, lo, bad, rd);
                shadow[a * 17][7:0] = exp[7:0];
            end
            check(lo == WR_EXP && bad == 0, "R5 lane write", {lo[15:0], bad[15:0]}, {16'(WR_EXP), 16'h0});
        end
        // R5 write with no lanes enabled changes nothing
        access(1'b1, 19'(3 * 17), 16'hFFFF, 2'b00, lo, bad, rd);
        check(bad == 0, "R5 empty write", bad, 0);

        // R3 R4 read sweep over every lane combination
        for (int a = 0; a < 16; a++) begin
            for (int b = 1; b < 4; b++) begin
                access(1'b0, 19'(a * 17), 16'h0, 2'(b), lo, bad, rd);
                msk = {(b[1] ? 8'hFF : 8'h00), (b[0] ? 8'hFF : 8'h00)};
                exp = shadow[a * 17] & msk;
                check(rd == exp, "R4 read data", rd, exp);
                check(lo == RD_EXP, "R3 read window", lo, RD_EXP);
                check(bad == 0, "R3 read signalling", bad, 0);
            end
        end

        // R7 turnaround after a read, measured from the done cycle
        access(1'b0, 19'(5 * 17), 16'h0, 2'b11, lo, bad, rd);
        t = 0;
        while (!req_ready && t < 50) begin
            t++;
            @(negedge clk);
        end
        check(t == TA_EXP, "R7 turnaround", t, TA_EXP);
        access(1'b1, 19'(5 * 17), 16'hBEEF, 2'b11, lo, bad, rd);
        shadow[5 * 17] = 16'hBEEF;
        check(bad == 0, "R7 write after read", bad, 0);
        check(clash_cnt == 0, "R6 R7 bus contention", clash_cnt, 0);

        // R9 retention with a request held pending
        @(negedge clk);
        ret_req   = 1'b1;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 19'(5 * 17);
        req_be    = 2'b11;
        @(negedge clk);
        check(ret_ack && mem_cs_n && !req_ready, "R9 parked",
              {ret_ack, mem_cs_n, req_ready}, 3'b110);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (rsp_done || !mem_cs_n || !ret_ack) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R9 request ignored", seen, 0);
        ret_req   = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check(!ret_ack, "R10 release", ret_ack, 0);
        t = 0;
        while (!req_ready && t < 100) begin
            t++;
            @(negedge clk);
        end
        check(t == RC_EXP, "R10 recovery wait", t, RC_EXP);
        access(1'b0, 19'(5 * 17), 16'h0, 2'b11, lo, bad, rd);
        check(rd == 16'hBEEF, "R10 data kept", rd, 16'hBEEF);
        access(1'b0, 19'(3 * 17), 16'h0, 2'b11, lo, bad, rd);
        check(rd == shadow[3 * 17], "R10 data kept", rd, shadow[3 * 17]);
        check(clash_cnt == 0, "R6 final contention", clash_cnt, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule